// File: doc/BRIEF.md
# Poly1305 Message Block Limb Converter

This block prepares one message block for a radix-2^26 Poly1305 accumulator. A 16-byte block arrives as a little-endian integer together with a count of valid bytes and a flag that marks it as a zero block. The converter clears every byte at or above the count and adds the pad bit. A partial block gets the byte value 0x01 in the first unused byte position. A full block gets bit 128 set, just above the data. The resulting 130-bit value is split into five 26-bit limbs that can be added straight into the accumulator limbs.

A second, independent path does the reverse. It takes five 26-bit limbs and packs them into one 130-bit little-endian value, where limb i occupies bits 26i+25 down to 26i. Each path carries a valid strobe alongside its data. The `OUT_REG` parameter selects a registered output stage (one cycle of latency, the default) or a purely combinational path.

Top module: `poly_block_unpack`

## Requirements
- R1: With the default registered output, `out_valid` equals `in_valid` from one cycle earlier and `pk_out_valid` equals `pk_valid` from one cycle earlier. Both are 0 after reset.
- R2: `out_limbs` carries limb i in bits [26i+25:26i]. Limb i equals bits 26i+25..26i of the padded 130-bit value: limb 0 holds bits 25:0 and limb 4 holds bits 129:104.
- R3: Input bytes at positions greater than or equal to the effective count contribute zero. Byte k occupies `in_block` bits [8k+7:8k].
- R4: For an effective count n below 16, including n = 0, byte n of the padded value is 0x01, and bits 128 and 129 are 0.
- R5: For an effective count of 16, bit 128 (limb 4 bit 24) is 1 and bit 129 is 0. Counts 17 to 31 act as 16.
- R6: When `in_zero` is 1, all limbs are zero with no pad bit, whatever the block and the count.
- R7: `pk_value` is the OR of each `pk_limbs` limb i shifted left by 26i, so the top two bits of limb 4 land in bits 129:128.
- R8: Packing the limbs produced by the unpacker returns the padded value (masked block plus pad bit) for every count from 0 to 16.

Top module ports follow; limb vectors are flat, limb i in bits [26i+25:26i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Unpack request strobe |
| in_block | input | 128 | Message block, byte k in bits [8k+7:8k] |
| in_count | input | 5 | Number of valid bytes, saturating at 16 |
| in_zero | input | 1 | Zero-block flag: output all-zero limbs |
| out_valid | output | 1 | Unpack result strobe |
| out_limbs | output | 130 | Five 26-bit limbs of the padded block |
| pk_valid | input | 1 | Pack request strobe |
| pk_limbs | input | 130 | Five 26-bit limbs to pack |
| pk_out_valid | output | 1 | Pack result strobe |
| pk_value | output | 130 | Packed 130-bit little-endian value |

## Verification
Both results arrive exactly one rising edge after their request, so the bench drives each stimulus on a falling edge and reads the result on the next falling edge. The round trip costs two edges: the limbs are read, driven into the pack inputs on that same falling edge, and the packed value is compared one falling edge later. Every count from 0 to 20 is swept over several byte patterns. Expected limbs are derived from a mask-and-add formula rather than a byte-by-byte copy.

// File: rtl/pbu_pkg.sv
package pbu_pkg;
  parameter int BLK_BYTES = 16;
  parameter int LIMB_W    = 26;
  parameter int N_LIMB    = 5;
  localparam int BLK_BITS = BLK_BYTES * 8;
  localparam int VAL_W    = LIMB_W * N_LIMB;
  localparam int CNT_W    = $clog2(BLK_BYTES + 1);
endpackage

// File: rtl/pbu_pad.sv
// Clears unused bytes and inserts the pad bit; produces the padded value.
module pbu_pad
  import pbu_pkg::*;
(
  input  logic [BLK_BITS-1:0] blk_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic                zero_i,
  output logic [VAL_W-1:0]    val_o
);
  logic [CNT_W-1:0]    n_sat;
  logic                full;
  logic [BLK_BITS-1:0] body;

  always_comb begin
    n_sat = (cnt_i >= CNT_W'(BLK_BYTES)) ? CNT_W'(BLK_BYTES) : cnt_i;
    full  = (n_sat == CNT_W'(BLK_BYTES));
  end

  for (genvar b = 0; b < BLK_BYTES; b++) begin : g_byte
    assign body[8*b +: 8] = (CNT_W'(b) <  n_sat) ? blk_i[8*b +: 8] :
                            (CNT_W'(b) == n_sat) ? 8'h01 : 8'h00;
  end

  always_comb begin
    val_o = '0;
    if (!zero_i) begin
      val_o[BLK_BITS-1:0] = body;
      val_o[BLK_BITS]     = full;
    end
  end
endmodule

// File: rtl/pbu_split.sv
// Splits the padded value into limbs of LIMB_W bits.
module pbu_split
  import pbu_pkg::*;
(
  input  logic [VAL_W-1:0] val_i,
  output logic [VAL_W-1:0] limbs_o
);
  for (genvar i = 0; i < N_LIMB; i++) begin : g_limb
    assign limbs_o[i*LIMB_W +: LIMB_W] = val_i[i*LIMB_W +: LIMB_W];
  end
endmodule

// File: rtl/pbu_join.sv
// Packs limbs into one value by shifting and ORing.
module pbu_join
  import pbu_pkg::*;
(
  input  logic [VAL_W-1:0] limbs_i,
  output logic [VAL_W-1:0] val_o
);
  always_comb begin
    val_o = '0;
    for (int i = 0; i < N_LIMB; i++) begin
      val_o = val_o | (VAL_W'(limbs_i[i*LIMB_W +: LIMB_W]) << (i*LIMB_W));
    end
  end
endmodule

// File: rtl/pbu_stage.sv
// Optional output register with a valid bit; data loads only on valid.
module pbu_stage #(
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_i,
  input  logic [W-1:0] d_i,
  output logic         v_o,
  output logic [W-1:0] d_o
);
  if (OUT_REG) begin : g_reg
    logic         v_q, v_n;
    logic [W-1:0] d_q, d_n;

    always_comb begin
      v_n = v_i;
      d_n = v_i ? d_i : d_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_n;
    end

    always_ff @(posedge clk) begin
      d_q <= d_n;
    end

    assign v_o = v_q;
    assign d_o = d_q;
  end else begin : g_comb
    assign v_o = v_i;
    assign d_o = d_i;
  end
endmodule

// File: rtl/poly_block_unpack.sv
module poly_block_unpack
  import pbu_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [BLK_BITS-1:0] in_block,
  input  logic [CNT_W-1:0]    in_count,
  input  logic                in_zero,
  output logic                out_valid,
  output logic [VAL_W-1:0]    out_limbs,
  input  logic                pk_valid,
  input  logic [VAL_W-1:0]    pk_limbs,
  output logic                pk_out_valid,
  output logic [VAL_W-1:0]    pk_value
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [VAL_W-1:0] padded;
  logic [VAL_W-1:0] limbs_c;
  logic [VAL_W-1:0] packed_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  pbu_pad   u_pad   (.blk_i(in_block), .cnt_i(in_count), .zero_i(in_zero), .val_o(padded));
  pbu_split u_split (.val_i(padded), .limbs_o(limbs_c));
  pbu_join  u_join  (.limbs_i(pk_limbs), .val_o(packed_c));

  pbu_stage #(.W(VAL_W), .OUT_REG(OUT_REG)) u_unp_stage (
    .clk(clk), .rst_n(rst_sync_n), .v_i(in_valid), .d_i(limbs_c),
    .v_o(out_valid), .d_o(out_limbs));

  pbu_stage #(.W(VAL_W), .OUT_REG(OUT_REG)) u_pk_stage (
    .clk(clk), .rst_n(rst_sync_n), .v_i(pk_valid), .d_i(packed_c),
    .v_o(pk_out_valid), .d_o(pk_value));
endmodule

// File: rtl/pbu_checker.sv
module pbu_checker
  import pbu_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             in_valid,
  input logic [CNT_W-1:0] in_count,
  input logic             in_zero,
  input logic             out_valid,
  input logic [VAL_W-1:0] out_limbs,
  input logic             pk_valid,
  input logic             pk_out_valid
);
  logic             d_valid, d_pkv, d_zero;
  logic [CNT_W-1:0] d_cnt;
  logic             d_full;

  if (OUT_REG) begin : g_dly
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        d_valid <= 1'b0;
        d_pkv   <= 1'b0;
      end else begin
        d_valid <= in_valid;
        d_pkv   <= pk_valid;
      end
    end
    always_ff @(posedge clk) begin
      if (in_valid) begin
        d_cnt  <= in_count;
        d_zero <= in_zero;
      end
    end
  end else begin : g_now
    assign d_valid = in_valid;
    assign d_pkv   = pk_valid;
    assign d_cnt   = in_count;
    assign d_zero  = in_zero;
  end

  assign d_full = (d_cnt >= CNT_W'(BLK_BYTES));

  a_r1_valid_follow: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid == d_valid);

  a_r7_pack_valid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pk_out_valid == d_pkv);

  a_r6_zero_block: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && d_zero) |-> (out_limbs == '0));

  a_r5_full_pad: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !d_zero && d_full) |-> (out_limbs[BLK_BITS] && !out_limbs[VAL_W-1]));

  a_r4_partial_pad: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !d_zero && !d_full) |->
      (out_limbs[VAL_W-1:BLK_BITS] == '0 && out_limbs[8*int'(d_cnt) +: 8] == 8'h01));
endmodule

bind poly_block_unpack pbu_checker #(.OUT_REG(OUT_REG)) u_pbu_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .in_valid(in_valid), .in_count(in_count),
  .in_zero(in_zero), .out_valid(out_valid), .out_limbs(out_limbs),
  .pk_valid(pk_valid), .pk_out_valid(pk_out_valid));

// File: tb/test_poly_block_unpack.sv
`timescale 1ns/1ps
module test_poly_block_unpack;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_block;
  logic [4:0]   in_count;
  logic         in_zero;
  logic         out_valid;
  logic [129:0] out_limbs;
  logic         pk_valid;
  logic [129:0] pk_limbs;
  logic         pk_out_valid;
  logic [129:0] pk_value;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2 clk = ~clk;

  poly_block_unpack i_poly_block_unpack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_block(in_block),
    .in_count(in_count), .in_zero(in_zero), .out_valid(out_valid),
    .out_limbs(out_limbs), .pk_valid(pk_valid), .pk_limbs(pk_limbs),
    .pk_out_valid(pk_out_valid), .pk_value(pk_value));

  task automatic check(input bit ok, input string req, input logic [129:0] act,
                       input logic [129:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Padded value by arithmetic: masked block plus one pad term.
  function automatic logic [129:0] pad_ref(input logic [127:0] blk, input int cnt,
                                           input bit zero);
    int n;
    logic [129:0] mask;
    if (zero) return '0;
    n = (cnt > 16) ? 16 : cnt;
    mask = (130'(1) << (8 * n)) - 130'(1);
    return (130'(blk) & mask) + (130'(1) << ((n < 16) ? 8 * n : 128));
  endfunction

  function automatic logic [127:0] pattern(input int p);
    logic [127:0] v;
    for (int b = 0; b < 16; b++) begin
      case (p)
        0: v[8*b +: 8] = 8'hFF;
        1: v[8*b +: 8] = 8'h00;
        2: v[8*b +: 8] = 8'(8'h10 + b);
        default: v[8*b +: 8] = 8'(8'hA7 * (b + 3) ^ 8'h5C);
      endcase
    end
    return v;
  endfunction

  task automatic run_unpack(input int p, input int cnt, input bit zero);
    logic [129:0] exp;
    logic [129:0] got;
    string req;
    in_valid = 1'b1;
    in_block = pattern(p);
    in_count = 5'(cnt);
    in_zero  = zero;
    exp = pad_ref(in_block, cnt, zero);
    @(negedge clk);
    in_valid = 1'b0;
    got = out_limbs;
    if (zero)           req = "R6 zero block";
    else if (cnt >= 16) req = "R5 R3 full pad";
    else                req = "R4 R3 partial pad";
    check(out_valid === 1'b1, "R1 out_valid", 130'(out_valid), 130'(1));
    for (int i = 0; i < 5; i++) begin
      check(got[26*i +: 26] === exp[26*i +: 26], req, 130'(got[26*i +: 26]),
            130'(exp[26*i +: 26]));
    end
    // R8 round trip through the pack path
    pk_valid = 1'b1;
    pk_limbs = got;
    @(negedge clk);
    pk_valid = 1'b0;
    check(pk_value === exp, "R8 round trip", pk_value, exp);
  endtask

  task automatic run_pack(input logic [25:0] l0, input logic [25:0] l1,
                          input logic [25:0] l2, input logic [25:0] l3,
                          input logic [25:0] l4);
    logic [129:0] exp;
    exp = 130'(l0) + 130'(l1) * (130'(1) << 26) + 130'(l2) * (130'(1) << 52)
        + 130'(l3) * (130'(1) << 78) + 130'(l4) * (130'(1) << 104);
    pk_valid = 1'b1;
    pk_limbs = {l4, l3, l2, l1, l0};
    @(negedge clk);
    pk_valid = 1'b0;
    check(pk_out_valid === 1'b1, "R7 pk_out_valid", 130'(pk_out_valid), 130'(1));
    check(pk_value === exp, "R7 pack", pk_value, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_block = '0; in_count = '0; in_zero = 1'b0;
    pk_valid = 1'b0; pk_limbs = '0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 reset out_valid", 130'(out_valid), 130'(0));
    check(pk_out_valid === 1'b0, "R1 reset pk_out_valid", 130'(pk_out_valid), 130'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid === 1'b0, "R1 idle out_valid", 130'(out_valid), 130'(0));

    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c <= 20; c++) run_unpack(p, c, 1'b0);
    end
    run_unpack(0, 5, 1'b1);
    run_unpack(3, 16, 1'b1);
    run_unpack(2, 0, 1'b1);

    // R1: valid drops one cycle after the strobe is removed
    @(negedge clk);
    check(out_valid === 1'b0, "R1 valid low", 130'(out_valid), 130'(0));

    run_pack(26'h3FFFFFF, 26'h3FFFFFF, 26'h3FFFFFF, 26'h3FFFFFF, 26'h3FFFFFF);
    run_pack(26'h0000001, 26'h0, 26'h0, 26'h0, 26'h3000000);
    run_pack(26'h1234567, 26'h2ABCDEF, 26'h0F0F0F0, 26'h1111111, 26'h2000001);
    // R2: limb 4 bit 24 on its own maps to bit 128
    run_pack(26'h0, 26'h0, 26'h0, 26'h0, 26'h1000000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule